// File: doc/BRIEF.md
# Filtered Channel Message Logger

The block collects 48-bit messages from several readout channels and records each accepted one in a 16-bit-wide message memory. Every stored record takes one four-word slot: three words of message payload, most significant first, then a word carrying the number of the channel it came from. A write pointer names the slot that the next record will fill. It steps by one slot for every stored record and returns to the start of the region after the last slot.

Channels present a message with a valid flag and hold it until the block pulses their ready line. When several channels are waiting, the lowest-numbered channel is served first. Before a record is written, a channel-number filter decides whether to keep it. The filter has an 8-bit pattern and an 8-bit per-bit compare enable. A message that fails the filter is still consumed, but nothing is written. A test mode repeats channel 0's message once on every channel, which exercises all lanes from a single source.

A simple host port reads and writes the message memory and reads or sets the control registers. Read data is registered.

Top module: `msg_logger`

## Requirements
- R1: A stored record fills four consecutive words at pointer+0..3. These hold message bits 47:32, bits 31:16, bits 15:0, and the zero-extended 8-bit channel number, in that order.
- R2: The write pointer is 14 bits wide and resets to 0. It advances by exactly 4 for each stored record. It is read at host register offset 0 (address bit 12 = 1, bits 1:0 = 0), and host writes to it are ignored.
- R3: After the record in the last slot (pointer 4092 with the default 4096-word region), the pointer wraps to 0. It always stays a multiple of 4 inside the region.
- R4: The filter register sits at host offset 1 and resets to 0x0000. Bits 7:0 hold the pattern and bits 15:8 are per-bit compare enables. A record is stored only if every enabled bit of its channel number equals the same bit of the pattern. With all enables clear, every record is stored.
- R5: A message rejected by the filter is still accepted with a ready pulse. It causes no memory write and no pointer change.
- R6: When several channels are valid, the lowest-numbered one is granted. ch_ready_o pulses for one cycle only on the granted channel, and at most one bit is ever set.
- R7: A new message is accepted only while the writer is idle or writing the last word of a slot. A stored record therefore blocks further grants for the next three cycles.
- R8: Test mode is enabled by host offset 2, bit 0, which resets to 0. In test mode, channel 0's message is offered once on each channel index in ascending order and stored with that index as its tag. Channel 0 sees ready only when the last copy is accepted. The inputs of the other channels are ignored and their ready lines stay low.
- R9: The host reads or writes a memory word when address bit 12 is 0. The addressed word or register appears on host_rdata_o one cycle after the address is presented, and host_rdata_o is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ch_valid_i | input | N_CH | Per-channel message present |
| ch_msg_i | input | N_CH*48 | Per-channel message, channel i at bits i*48 +: 48 |
| ch_ready_o | output | N_CH | Per-channel accept pulse |
| host_addr_i | input | ADDR_W+1 | Host address; top bit selects registers |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, one cycle after address |

## Verification
ch_ready_o is combinational on the current inputs and writer state. The reference model predicts it in the same cycle and compares it on every clock. The model tracks grants in that cycle and, after a stored record, the four-cycle window before the next grant. Memory words and the pointer settle by the fourth edge after a grant. The bench therefore reads them only after all sources have drained and the model writer is idle. Each host read is sampled one full cycle after its address is driven, matching the registered read path.

// File: rtl/msg_logger_pkg.sv
package msg_logger_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned MSG_W      = 48;
  localparam int unsigned SLOT_WORDS = 4;
  localparam int unsigned CNT_W      = $clog2(SLOT_WORDS);
  localparam int unsigned TAG_W      = 8;

  typedef logic [MSG_W-1:0]  msg_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [TAG_W-1:0]  tag_t;

  typedef struct packed {
    logic [TAG_W-1:0] en;
    logic [TAG_W-1:0] pat;
  } filt_t;

  function automatic logic filt_pass(filt_t f, tag_t tag);
    return ((tag ^ f.pat) & f.en) == '0;
  endfunction
endpackage

// File: rtl/msg_stress_fan.sv
module msg_stress_fan
  import msg_logger_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stress_i,
  input  logic [N_CH-1:0] valid_i,
  input  msg_t            msg_i [N_CH],
  input  logic [N_CH-1:0] take_i,
  output logic [N_CH-1:0] lane_valid_o,
  output msg_t            lane_msg_o [N_CH],
  output logic [N_CH-1:0] src_ready_o
);
  logic [N_CH-1:0] done_q;
  logic            last_copy;

  for (genvar i = 0; i < N_CH; i++) begin : g_lane
    assign lane_valid_o[i] = stress_i ? (valid_i[0] & ~done_q[i]) : valid_i[i];
    assign lane_msg_o[i]   = stress_i ? msg_i[0] : msg_i[i];
  end

  // channel 0 is released once every lane has taken its copy
  assign last_copy = (|take_i) && ((done_q | take_i) == '1);

  always_comb begin
    if (stress_i) begin
      src_ready_o    = '0;
      src_ready_o[0] = last_copy;
    end else begin
      src_ready_o = take_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  done_q <= '0;
    else if (!stress_i || last_copy) done_q <= '0;
    else                          done_q <= done_q | take_i;
  end
endmodule

// File: rtl/msg_arbiter.sv
module msg_arbiter #(
  parameter int unsigned N_CH = 4
) (
  input  logic [N_CH-1:0] req_i,
  input  logic            en_i,
  output logic [N_CH-1:0] grant_o
);
  logic [N_CH:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N_CH; i++) begin : g_prio
    assign grant_o[i]  = en_i & req_i[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | req_i[i];
  end
endmodule

// File: rtl/msg_writer.sv
module msg_writer
  import msg_logger_pkg::*;
#(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned MEM_WORDS = 4096,
  parameter int unsigned PTR_W     = 14,
  parameter int unsigned ADDR_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   grant_i,
  input  msg_t              lane_msg_i [N_CH],
  input  filt_t             filt_i,
  output logic              accept_o,
  output logic              log_we_o,
  output logic [ADDR_W-1:0] log_addr_o,
  output word_t             log_wdata_o,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(MEM_WORDS - SLOT_WORDS);
  localparam logic [PTR_W-1:0] STEP      = PTR_W'(SLOT_WORDS);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SLOT_WORDS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q, ptr_next;
  msg_t             hold_msg_q, sel_msg;
  tag_t             hold_tag_q, sel_tag;
  logic             last_word, store;

  always_comb begin
    sel_msg = '0;
    sel_tag = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (grant_i[i]) begin
        sel_msg = lane_msg_i[i];
        sel_tag = TAG_W'(i);
      end
    end
  end

  assign last_word = busy_q && (cnt_q == LAST_CNT);
  assign accept_o  = !busy_q || last_word;
  assign store     = (|grant_i) && accept_o && filt_pass(filt_i, sel_tag);
  assign ptr_next  = (ptr_q == LAST_SLOT) ? '0 : ptr_q + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      ptr_q      <= '0;
      hold_msg_q <= '0;
      hold_tag_q <= '0;
    end else begin
      if (last_word) ptr_q <= ptr_next;
      if (store) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        hold_msg_q <= sel_msg;
        hold_tag_q <= sel_tag;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_word) busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (cnt_q)
      2'd0:    log_wdata_o = hold_msg_q[47:32];
      2'd1:    log_wdata_o = hold_msg_q[31:16];
      2'd2:    log_wdata_o = hold_msg_q[15:0];
      default: log_wdata_o = WORD_W'(hold_tag_q);
    endcase
  end

  assign log_we_o   = busy_q;
  assign log_addr_o = ptr_q[ADDR_W-1:0] + ADDR_W'(cnt_q);
  assign ptr_o      = ptr_q;
endmodule

// File: rtl/msg_mem.sv
module msg_mem
  import msg_logger_pkg::*;
#(
  parameter int unsigned DEPTH  = 4096,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              log_we_i,
  input  logic [ADDR_W-1:0] log_addr_i,
  input  word_t             log_wdata_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  word_t             host_wdata_i,
  output word_t             host_rdata_o
);
  word_t mem_q [DEPTH];

  // logger write placed last: it wins on an address clash
  always_ff @(posedge clk_i) begin
    if (host_we_i) mem_q[host_addr_i] <= host_wdata_i;
    if (log_we_i)  mem_q[log_addr_i]  <= log_wdata_i;
    host_rdata_o <= mem_q[host_addr_i];
  end
endmodule

// File: rtl/msg_logger.sv
module msg_logger
  import msg_logger_pkg::*;
#(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned MEM_WORDS = 4096,
  parameter int unsigned PTR_W     = 14,
  parameter int unsigned ADDR_W    = $clog2(MEM_WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       ch_valid_i,
  input  logic [N_CH*MSG_W-1:0] ch_msg_i,
  output logic [N_CH-1:0]       ch_ready_o,
  input  logic [ADDR_W:0]       host_addr_i,
  input  logic                  host_we_i,
  input  logic [WORD_W-1:0]     host_wdata_i,
  output logic [WORD_W-1:0]     host_rdata_o
);
  msg_t            raw_msg  [N_CH];
  msg_t            lane_msg [N_CH];
  logic [N_CH-1:0] lane_valid, grant;
  logic            accept_w;
  logic            log_we;
  logic [ADDR_W-1:0] log_addr;
  word_t           log_wdata, mem_rdata;
  logic [PTR_W-1:0] ptr_w;

  filt_t filter_q;
  logic  stress_q;
  logic  sel_mem_q;
  word_t reg_rdata_q;
  logic  reg_sel, mem_we, reg_we;

  for (genvar i = 0; i < N_CH; i++) begin : g_unpack
    assign raw_msg[i] = ch_msg_i[i*MSG_W +: MSG_W];
  end

  msg_stress_fan #(.N_CH(N_CH)) u_fan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stress_i     (stress_q),
    .valid_i      (ch_valid_i),
    .msg_i        (raw_msg),
    .take_i       (grant),
    .lane_valid_o (lane_valid),
    .lane_msg_o   (lane_msg),
    .src_ready_o  (ch_ready_o)
  );

  msg_arbiter #(.N_CH(N_CH)) u_arb (
    .req_i   (lane_valid),
    .en_i    (accept_w),
    .grant_o (grant)
  );

  msg_writer #(
    .N_CH(N_CH), .MEM_WORDS(MEM_WORDS), .PTR_W(PTR_W), .ADDR_W(ADDR_W)
  ) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant),
    .lane_msg_i  (lane_msg),
    .filt_i      (filter_q),
    .accept_o    (accept_w),
    .log_we_o    (log_we),
    .log_addr_o  (log_addr),
    .log_wdata_o (log_wdata),
    .ptr_o       (ptr_w)
  );

  assign reg_sel = host_addr_i[ADDR_W];
  assign mem_we  = host_we_i && !reg_sel;
  assign reg_we  = host_we_i && reg_sel;

  msg_mem #(.DEPTH(MEM_WORDS), .ADDR_W(ADDR_W)) u_mem (
    .clk_i        (clk_i),
    .log_we_i     (log_we),
    .log_addr_i   (log_addr),
    .log_wdata_i  (log_wdata),
    .host_we_i    (mem_we),
    .host_addr_i  (host_addr_i[ADDR_W-1:0]),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filter_q    <= '0;
      stress_q    <= 1'b0;
      sel_mem_q   <= 1'b0;
      reg_rdata_q <= '0;
    end else begin
      if (reg_we) begin
        unique case (host_addr_i[1:0])
          2'd1:    filter_q <= host_wdata_i;
          2'd2:    stress_q <= host_wdata_i[0];
          default: ;
        endcase
      end
      sel_mem_q <= !reg_sel;
      unique case (host_addr_i[1:0])
        2'd0:    reg_rdata_q <= WORD_W'(ptr_w);
        2'd1:    reg_rdata_q <= filter_q;
        2'd2:    reg_rdata_q <= WORD_W'(stress_q);
        default: reg_rdata_q <= '0;
      endcase
    end
  end

  assign host_rdata_o = sel_mem_q ? mem_rdata : reg_rdata_q;
endmodule

// File: rtl/msg_logger_chk.sv
module msg_logger_chk #(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned PTR_W     = 14,
  parameter int unsigned MEM_WORDS = 4096
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  ch_ready_o,
  input logic [PTR_W-1:0] ptr_w,
  input logic             stress_q,
  input logic             accept_w
);
  // R6
  ready_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_ready_o));

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_w != $past(ptr_w)) |-> (ptr_w == PTR_W'($past(ptr_w) + PTR_W'(4)) || ptr_w == '0));

  // R3
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_w[1:0] == 2'b00) && (ptr_w <= PTR_W'(MEM_WORDS - 4)));

  // R8
  stress_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stress_q |-> (ch_ready_o[N_CH-1:1] == '0));

  // R7
  busy_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_w |-> (ch_ready_o == '0));
endmodule

bind msg_logger msg_logger_chk #(
  .N_CH(N_CH), .PTR_W(PTR_W), .MEM_WORDS(MEM_WORDS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ch_ready_o (ch_ready_o),
  .ptr_w      (ptr_w),
  .stress_q   (stress_q),
  .accept_w   (accept_w)
);

// File: tb/msg_logger_bench.sv
`timescale 1ns/1ps
module msg_logger_bench;
  localparam int N_CH = 4;
  localparam int MEM_WORDS = 4096;
  localparam int ALL = (1 << N_CH) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_CH-1:0] ch_valid = '0;
  logic [N_CH*48-1:0] ch_msg = '0;
  logic [N_CH-1:0] ch_ready;
  logic [12:0] h_addr = '0;
  logic h_we = 1'b0;
  logic [15:0] h_wdata = '0, h_rdata;

  msg_logger u_msg_logger (
    .clk_i(clk), .rst_ni(rst_n), .ch_valid_i(ch_valid), .ch_msg_i(ch_msg),
    .ch_ready_o(ch_ready), .host_addr_i(h_addr), .host_we_i(h_we),
    .host_wdata_i(h_wdata), .host_rdata_o(h_rdata));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, seq = 0;
  logic [47:0] src_q [N_CH][$];
  logic [15:0] exp_mem [int];
  int m_busy = 0, m_ptr = 0, m_done = 0, prev_grant = -1;
  bit model_on = 0, m_stress = 0;
  logic [15:0] m_filt = '0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic bit pass(int tag);
    for (int b = 0; b < 8; b++)
      if (m_filt[8+b] && (tag[b] != m_filt[b])) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // cycle model: settle last edge, drive inputs, predict ready
  always @(negedge clk) if (model_on) begin
    if (m_busy > 0) m_busy--;
    if (prev_grant >= 0) begin
      logic [47:0] m;
      m = m_stress ? src_q[0][0] : src_q[prev_grant][0];
      if (pass(prev_grant)) begin
        exp_mem[m_ptr]   = m[47:32];
        exp_mem[m_ptr+1] = m[31:16];
        exp_mem[m_ptr+2] = m[15:0];
        exp_mem[m_ptr+3] = 16'(prev_grant);
        m_ptr = (m_ptr == MEM_WORDS - 4) ? 0 : m_ptr + 4;
        m_busy = 4;
      end
      if (m_stress) begin
        m_done |= (1 << prev_grant);
        if (m_done == ALL) begin void'(src_q[0].pop_front()); m_done = 0; end
      end else void'(src_q[prev_grant].pop_front());
    end
    for (int i = 0; i < N_CH; i++) begin
      ch_valid[i] = src_q[i].size() > 0;
      ch_msg[i*48 +: 48] = (src_q[i].size() > 0) ? src_q[i][0] : 48'h0;
    end
    #1;
    begin
      int g;
      logic [N_CH-1:0] er;
      g = -1; er = '0;
      if (m_busy <= 1)
        for (int i = N_CH - 1; i >= 0; i--) begin
          bit v;
          v = m_stress ? (src_q[0].size() > 0 && !m_done[i]) : (src_q[i].size() > 0);
          if (v) g = i;
        end
      if (g >= 0) begin
        if (m_stress) er[0] = ((m_done | (1 << g)) == ALL);
        else er[g] = 1'b1;
      end
      chk("R6/R7 ready per cycle", 32'(ch_ready), 32'(er));
      prev_grant = g;
    end
  end

  task automatic push(int c, int n);
    for (int j = 0; j < n; j++) begin
      seq++;
      src_q[c].push_back({8'(c), 24'(seq), 16'(seq * 3 + 7)});
    end
  endtask

  task automatic drain();
    while (1) begin
      bit empty;
      empty = (m_busy == 0) && (prev_grant < 0);
      for (int i = 0; i < N_CH; i++) if (i == 0 || !m_stress) if (src_q[i].size() > 0) empty = 0;
      if (empty) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic hwrite(logic [12:0] a, logic [15:0] d);
    @(negedge clk); h_addr = a; h_we = 1'b1; h_wdata = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic hread(logic [12:0] a, output logic [15:0] d);
    @(negedge clk); h_addr = a; h_we = 1'b0;
    @(negedge clk); #2; d = h_rdata;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk("R9 rdata in reset", 32'(h_rdata), 0);
    rst_n = 1'b1;
    model_on = 1;
    hread(13'h1000, d); chk("R2 ptr reset", d, 0);
    hread(13'h1001, d); chk("R4 filter reset", d, 0);
    hread(13'h1002, d); chk("R8 stress reset", d, 0);

    // open filter, contention on all channels
    for (int c = 0; c < N_CH; c++) push(c, 3);
    drain();
    hread(13'h1000, d); chk("R2 ptr after 12 records", d, 16'(m_ptr));
    hwrite(13'h1000, 16'h1234);
    hread(13'h1000, d); chk("R2 ptr write ignored", d, 16'(m_ptr));

    // only channel 2 passes: en=0x03 pat=0x02
    m_filt = 16'h0302; hwrite(13'h1001, m_filt);
    hread(13'h1001, d); chk("R4 filter readback", d, 16'h0302);
    for (int c = 0; c < N_CH; c++) push(c, 2);
    drain();
    hread(13'h1000, d); chk("R5 ptr counts stored only", d, 16'(m_ptr));

    // odd channels: en=0x01 pat=0x01
    m_filt = 16'h0101; hwrite(13'h1001, m_filt);
    for (int c = 0; c < N_CH; c++) push(c, 2);
    drain();
    hread(13'h1000, d); chk("R4 odd filter ptr", d, 16'(m_ptr));

    // test mode, junk on channel 1 must be ignored
    m_filt = 16'h0000; hwrite(13'h1001, m_filt);
    hwrite(13'h1002, 16'h0001); m_stress = 1;
    push(1, 1);
    push(0, 3);
    drain();
    chk("R8 channel 1 untouched", 32'(src_q[1].size()), 1);
    hread(13'h1000, d); chk("R8 ptr after copies", d, 16'(m_ptr));
    hwrite(13'h1002, 16'h0000); m_stress = 0;
    drain();

    // run past the end of the region
    for (int k = 0; k < (MEM_WORDS - m_ptr) / 4 + 3; k++) push(k % N_CH, 1);
    drain();
    hread(13'h1000, d); chk("R3 ptr after wrap", d, 16'(m_ptr));

    hwrite(13'h0ABD, 16'hBEEF); exp_mem[12'hABD] = 16'hBEEF;
    hread(13'h0ABD, d); chk("R9 host mem write/read", d, 16'hBEEF);

    foreach (exp_mem[a]) begin
      hread(13'(a), d);
      chk("R1 memory word", d, exp_mem[a]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule